// File: doc/BRIEF.md
# Odd-Parity Bus Transceiver with Registered Error Flag

This block joins a narrow data bus (side A, data only) to a wider bus (side B, the same data plus one parity bit). Traffic from A to B leaves with a freshly generated odd-parity bit. Traffic from B to A is passed through unchanged, and its parity is tested. The test result is loaded into an error-flag register on each rising clock edge. Data keeps its polarity in both directions. Each pad is modelled as a data-out value plus a drive enable, so the enclosing chip decides how the tri-state pads are built.

The direction comes from two active-low output enables, one per side. The decoder names four link states:
- `LINK_ISOLATED`: both enables high, so neither side is driven.
- `LINK_A2B`: only the B enable is low, so B is driven from A.
- `LINK_B2A`: only the A enable is low, so A is driven from B.
- `LINK_CONTENDED`: both enables low. Neither side is driven, which avoids a bus fight.

The error flag is a two-state machine, `FLAG_CLEAR` and `FLAG_SET`. The transition `FLAG_CLEAR -> FLAG_SET` is taken on a clock edge that samples a bad B word while the link is `LINK_B2A`. The transition `FLAG_SET -> FLAG_CLEAR` is taken on any clock edge that does not sample one. An asynchronous active-low clear forces `FLAG_CLEAR` and holds it there, whatever the clock does. The error pin behaves like an open-collector pin: it only ever pulls low.

Top module: `parity_xcvr`

## Requirements
- R1: With a_oe_n=1 and b_oe_n=0 (`LINK_A2B`), b_drive=1 and a_drive=0. b_out equals a_in bit for bit. b_par_out makes the 9 bits {b_par_out, b_out} hold an odd number of ones.
- R2: With a_oe_n=0 and b_oe_n=1 (`LINK_B2A`), a_drive=1 and b_drive=0, and a_out equals b_in bit for bit.
- R3: With both enables high (`LINK_ISOLATED`), a_drive=0 and b_drive=0.
- R4: With both enables low (`LINK_CONTENDED`), a_drive=0 and b_drive=0.
- R5: On a rising clk edge with clr_n=1, the flag enters `FLAG_SET` if the link is `LINK_B2A` and {b_par_in, b_in} holds an even number of ones. Otherwise it enters `FLAG_CLEAR`.
- R6: The flag changes only on a rising clk edge or through clr_n. Input changes between edges leave the error outputs unchanged.
- R7: While clr_n=0 the flag is `FLAG_CLEAR` at once, without a clock edge, and it stays there across clock edges.
- R8: In `FLAG_SET`, err_drive=1 and err_n=0. In `FLAG_CLEAR`, err_drive=0 and err_n=1. The pin is never driven high, so err_drive=1 implies err_n=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error-flag register |
| clr_n | input | 1 | Asynchronous active-low clear of the error flag |
| a_oe_n | input | 1 | Active-low enable for driving side A |
| b_oe_n | input | 1 | Active-low enable for driving side B |
| a_in | input | DATA_W (8) | Value received on side A |
| a_out | output | DATA_W (8) | Value for side A pads |
| a_drive | output | 1 | Drive enable for side A pads |
| b_in | input | DATA_W (8) | Data received on side B |
| b_par_in | input | 1 | Parity bit received on side B |
| b_out | output | DATA_W (8) | Data for side B pads |
| b_par_out | output | 1 | Generated odd-parity bit for side B |
| b_drive | output | 1 | Drive enable for side B pads, parity included |
| err_n | output | 1 | Active-low error level of the open-collector pin |
| err_drive | output | 1 | Pull-down enable of the error pin |

## Verification
Every one of the 256 byte values is sent from A to B. This covers all parity outcomes, and it shows that data reaches B unchanged and with the correct parity bit.

Every byte is also sent from B to A twice: once with its correct parity bit, and once with a single flipped bit, where the position of the flip rotates over all nine bits. Comparing the two runs shows that the checker flags exactly the words with an even number of ones, whichever bit is wrong.

A bad word is also presented in the isolated and contended link states, which shows that only `LINK_B2A` can set the flag. Inputs are changed between clock edges to show that the flag moves only on an edge. A low pulse on the clear is held across clock edges to show that the clear wins over the clock.

// File: rtl/parity_xcvr_pkg.sv
package parity_xcvr_pkg;

    typedef enum logic [1:0] {
        LINK_ISOLATED  = 2'b00,
        LINK_A2B       = 2'b01,
        LINK_B2A       = 2'b10,
        LINK_CONTENDED = 2'b11
    } link_state_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;

endpackage

// File: rtl/parity_xor_chain.sv
module parity_xor_chain #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bits,
    output logic             xor_all
);

    logic [WIDTH:0] acc;

    assign acc[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_stage
            assign acc[i+1] = acc[i] ^ bits[i];
        end
    endgenerate

    assign xor_all = acc[WIDTH];

endmodule

// File: rtl/link_decoder.sv
module link_decoder
    import parity_xcvr_pkg::*;
(
    input  logic a_oe_n,
    input  logic b_oe_n,
    output logic a_drive,
    output logic b_drive,
    output logic check_en
);

    link_state_e link;

    always_comb begin
        unique case ({a_oe_n, b_oe_n})
            2'b11:   link = LINK_ISOLATED;
            2'b10:   link = LINK_A2B;
            2'b01:   link = LINK_B2A;
            default: link = LINK_CONTENDED;
        endcase
    end

    always_comb begin
        a_drive  = 1'b0;
        b_drive  = 1'b0;
        check_en = 1'b0;
        unique case (link)
            LINK_ISOLATED: begin
            end
            LINK_A2B: begin
                b_drive = 1'b1;
            end
            LINK_B2A: begin
                a_drive  = 1'b1;
                check_en = 1'b1;
            end
            LINK_CONTENDED: begin
            end
        endcase
    end

endmodule

// File: rtl/error_flag_fsm.sv
module error_flag_fsm
    import parity_xcvr_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic sample_bad,
    output logic err_n,
    output logic err_drive
);

    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= FLAG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            FLAG_CLEAR: state_d = sample_bad ? FLAG_SET : FLAG_CLEAR;
            FLAG_SET:   state_d = sample_bad ? FLAG_SET : FLAG_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLAG_CLEAR: begin
                err_n     = 1'b1;
                err_drive = 1'b0;
            end
            FLAG_SET: begin
                err_n     = 1'b0;
                err_drive = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              a_oe_n,
    input  logic              b_oe_n,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive,
    input  logic [DATA_W-1:0] b_in,
    input  logic              b_par_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_par_out,
    output logic              b_drive,
    output logic              err_n,
    output logic              err_drive
);

    localparam int WORD_W = DATA_W + 1;

    logic a_xor;
    logic b_xor;
    logic check_en;

    link_decoder u_link (
        .a_oe_n   (a_oe_n),
        .b_oe_n   (b_oe_n),
        .a_drive  (a_drive),
        .b_drive  (b_drive),
        .check_en (check_en)
    );

    parity_xor_chain #(.WIDTH(DATA_W)) u_gen (
        .bits    (a_in),
        .xor_all (a_xor)
    );

    parity_xor_chain #(.WIDTH(WORD_W)) u_chk (
        .bits    ({b_par_in, b_in}),
        .xor_all (b_xor)
    );

    assign b_out     = a_in;
    assign b_par_out = ~a_xor;
    assign a_out     = b_in;

    error_flag_fsm u_flag (
        .clk        (clk),
        .clr_n      (clr_n),
        .sample_bad (check_en & ~b_xor),
        .err_n      (err_n),
        .err_drive  (err_drive)
    );

endmodule

// File: rtl/parity_xcvr_chk.sv
module parity_xcvr_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              clr_n,
    input logic              a_oe_n,
    input logic              b_oe_n,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] a_out,
    input logic              a_drive,
    input logic [DATA_W-1:0] b_in,
    input logic              b_par_in,
    input logic [DATA_W-1:0] b_out,
    input logic              b_par_out,
    input logic              b_drive,
    input logic              err_n,
    input logic              err_drive
);

    // R1
    a2b_odd_chk: assert property (@(posedge clk)
        (!b_oe_n && a_oe_n) |-> (b_drive && !a_drive && b_out == a_in
                                 && ($countones({b_par_out, b_out}) % 2 == 1)));

    // R2
    b2a_true_chk: assert property (@(posedge clk)
        (!a_oe_n && b_oe_n) |-> (a_drive && !b_drive && a_out == b_in));

    // R3
    isolate_chk: assert property (@(posedge clk)
        (a_oe_n && b_oe_n) |-> (!a_drive && !b_drive));

    // R4
    no_fight_chk: assert property (@(posedge clk)
        (!a_oe_n && !b_oe_n) |-> (!a_drive && !b_drive));

    // R5
    flag_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!a_oe_n && b_oe_n && ($countones({b_par_in, b_in}) % 2 == 0)) |=> err_drive);

    // R5
    flag_drop_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !(!a_oe_n && b_oe_n && ($countones({b_par_in, b_in}) % 2 == 0)) |=> !err_drive);

    // R7
    clear_hold_chk: assert property (@(posedge clk)
        !clr_n |-> (!err_drive && err_n));

    // R8
    open_drain_chk: assert property (@(posedge clk)
        err_drive |-> !err_n);

endmodule

bind parity_xcvr parity_xcvr_chk #(.DATA_W(DATA_W)) u_chk_bind (
    .clk       (clk),
    .clr_n     (clr_n),
    .a_oe_n    (a_oe_n),
    .b_oe_n    (b_oe_n),
    .a_in      (a_in),
    .a_out     (a_out),
    .a_drive   (a_drive),
    .b_in      (b_in),
    .b_par_in  (b_par_in),
    .b_out     (b_out),
    .b_par_out (b_par_out),
    .b_drive   (b_drive),
    .err_n     (err_n),
    .err_drive (err_drive)
);

// File: tb/tb_parity_xcvr.sv
module tb_parity_xcvr;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;

    logic              clk = 1'b0;
    logic              clr_n = 1'b0;
    logic              a_oe_n = 1'b1;
    logic              b_oe_n = 1'b1;
    logic [DATA_W-1:0] a_in = '0;
    logic [DATA_W-1:0] b_in = '0;
    logic              b_par_in = 1'b0;
    logic [DATA_W-1:0] a_out, b_out;
    logic              a_drive, b_drive, b_par_out, err_n, err_drive;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_xcvr #(.DATA_W(DATA_W)) dut (
        .clk(clk), .clr_n(clr_n), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out),
        .b_par_out(b_par_out), .b_drive(b_drive),
        .err_n(err_n), .err_drive(err_drive)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic odd_bit(input logic [DATA_W-1:0] d);
        return ($countones(d) % 2 == 0) ? 1'b1 : 1'b0;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        #1;
        check("R7 reset err_drive", {15'd0, err_drive}, 16'd0);
        check("R8 reset err_n", {15'd0, err_n}, 16'd1);
        check("R3 reset a_drive", {15'd0, a_drive}, 16'd0);
        check("R3 reset b_drive", {15'd0, b_drive}, 16'd0);
        clr_n = 1'b1;
    endtask

    task automatic t_a_to_b_all();
        @(negedge clk);
        a_oe_n = 1'b1;
        b_oe_n = 1'b0;
        for (int v = 0; v < 256; v++) begin
            a_in = v[DATA_W-1:0];
            #1;
            check("R1 b_out", {8'd0, b_out}, {8'd0, a_in});
            check("R1 b_par_out", {15'd0, b_par_out}, {15'd0, odd_bit(a_in)});
            check("R1 drives", {14'd0, a_drive, b_drive}, 16'd1);
        end
        @(posedge clk);
        #1;
        check("R5 no flag in A2B", {15'd0, err_drive}, 16'd0);
    endtask

    task automatic t_b_to_a_all();
        for (int v = 0; v < 256; v++) begin
            for (int bad = 0; bad < 2; bad++) begin
                logic [8:0] word;
                @(negedge clk);
                a_oe_n = 1'b0;
                b_oe_n = 1'b1;
                word = {odd_bit(v[DATA_W-1:0]), v[DATA_W-1:0]};
                if (bad == 1) word[v % 9] = ~word[v % 9];
                b_in     = word[7:0];
                b_par_in = word[8];
                #1;
                check("R2 a_out", {8'd0, a_out}, {8'd0, b_in});
                check("R2 drives", {14'd0, a_drive, b_drive}, 16'd2);
                @(posedge clk);
                #1;
                check("R5 flag after edge", {15'd0, err_drive}, {15'd0, bad[0]});
                check("R8 err_n level", {15'd0, err_n}, {15'd0, ~bad[0]});
            end
        end
    endtask

    task automatic t_isolate_and_contend();
        @(negedge clk);
        b_in = 8'h03;
        b_par_in = 1'b0;
        a_oe_n = 1'b1;
        b_oe_n = 1'b1;
        #1;
        check("R3 isolated drives", {14'd0, a_drive, b_drive}, 16'd0);
        @(posedge clk);
        #1;
        check("R5 no flag when isolated", {15'd0, err_drive}, 16'd0);
        @(negedge clk);
        a_oe_n = 1'b0;
        b_oe_n = 1'b0;
        #1;
        check("R4 contended drives", {14'd0, a_drive, b_drive}, 16'd0);
        @(posedge clk);
        #1;
        check("R5 no flag when contended", {15'd0, err_drive}, 16'd0);
    endtask

    task automatic t_edge_only();
        @(negedge clk);
        a_oe_n = 1'b0;
        b_oe_n = 1'b1;
        b_in = 8'h55;
        b_par_in = 1'b1;
        @(posedge clk);
        #1;
        check("R5 clean word", {15'd0, err_drive}, 16'd0);
        @(negedge clk);
        b_par_in = 1'b0;
        #2;
        check("R6 no change before edge", {15'd0, err_drive}, 16'd0);
        @(posedge clk);
        #1;
        check("R6 set at edge", {15'd0, err_drive}, 16'd1);
        @(negedge clk);
        b_par_in = 1'b1;
        #2;
        check("R6 held before edge", {15'd0, err_drive}, 16'd1);
        check("R8 held low", {15'd0, err_n}, 16'd0);
        @(posedge clk);
        #1;
        check("R6 cleared at edge", {15'd0, err_drive}, 16'd0);
    endtask

    task automatic t_async_clear();
        @(negedge clk);
        a_oe_n = 1'b0;
        b_oe_n = 1'b1;
        b_in = 8'h0F;
        b_par_in = 1'b0;
        @(posedge clk);
        #1;
        check("R5 set before clear", {15'd0, err_drive}, 16'd1);
        #1;
        clr_n = 1'b0;
        #1;
        check("R7 async clear", {15'd0, err_drive}, 16'd0);
        check("R8 released", {15'd0, err_n}, 16'd1);
        repeat (3) @(posedge clk);
        #1;
        check("R7 held through edges", {15'd0, err_drive}, 16'd0);
        @(negedge clk);
        clr_n = 1'b1;
        #1;
        check("R7 still clear after release", {15'd0, err_drive}, 16'd0);
        @(posedge clk);
        #1;
        check("R5 set after release", {15'd0, err_drive}, 16'd1);
    endtask

    initial begin
        t_reset();
        t_a_to_b_all();
        t_b_to_a_all();
        t_isolate_and_contend();
        t_edge_only();
        t_async_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule